// File: doc/BRIEF.md
# Processor Bus Transfer Terminator

This block closes the data phase of every transaction on a 60x-style processor bus. A transfer start is sampled only while the block is idle. The block then captures the transfer type, the address-space flags, the burst indicator, the burst-length setting and the two configuration bits. From that point it either acknowledges each data beat or ends the transaction with a single error acknowledge. A done pulse marks the end of every transaction, so the surrounding logic can track bus ownership without decoding the termination signals itself.

Each captured transaction is classified as supported or unsupported. Four cases are unsupported:
- direct-store accesses;
- external-control reads and writes;
- writes to the interrupt-acknowledge space;
- writes to flash while flash writes are disabled.

A processor-to-PCI transaction also becomes unsupported if the downstream side aborts it during its data phase. When error signalling is enabled, such a transaction ends with an error acknowledge and gets no data acknowledge. When error signalling is disabled, it completes with ordinary acknowledges for its full beat count, so the bus never hangs. A wait-state request holds the acknowledge low for as many cycles as it is held, which stretches any beat.

Top module: `xfer_term`

## Requirements
- R1: After reset, `ta`, `tea` and `done` are low. A start is then accepted on the first clock edge where `ts` is high.
- R2: A non-burst transfer (`burst`=0) gets exactly one `ta` beat. With no wait request, this beat comes in the cycle after the accepting edge. `ta` is low in the cycle after the beat.
- R3: A burst transfer (`burst`=1) gets exactly `burst_len`+1 `ta` beats, using the `burst_len` value captured with the start. With the default width, `burst_len`=3 gives the four beats of an 8-word burst.
- R4: In a data-phase cycle where `wait_req` is high and no error is signalled, `ta` stays low and no beat completes. The beats resume when `wait_req` drops, and the total beat count is unchanged.
- R5: `ttype` is encoded as 00 read, 01 write, 10 direct-store and 11 external-control. Codes 10 and 11 are unsupported whatever the space flags are.
- R6: Two writes (`ttype`=01) are unsupported: a write with `sp_iack`=1, and a write with `sp_flash`=1 while `flash_wr_en`=0. A read to either space is supported, and so is a flash write with `flash_wr_en`=1.
- R7: Consider a transfer with `sp_pci`=1 and error signalling enabled. If `pci_abort` is high in any of its data-phase cycles, `tea` rises in that cycle even during a wait. Earlier beats are kept. For a transfer with `sp_pci`=0, `pci_abort` has no effect.
- R8: With `err_en`=1 captured, an unsupported transfer raises `tea` in the first data-phase cycle and never raises `ta`.
- R9: `tea` is a single-cycle pulse. It is never high together with `ta`, and no `ta` follows it within the same transaction.
- R10: With `err_en`=0 captured, `tea` never rises. An unsupported or aborted transfer completes with its full count of `ta` beats.
- R11: `done` is a one-cycle pulse in the cycle after the last `ta` or after `tea`. `ta` and `tea` are low in that cycle.
- R12: `ts` is ignored while a transaction is in progress. It neither restarts nor lengthens the transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts | input | 1 | Transfer start, sampled only while idle |
| ttype | input | 2 | Transfer type: 00 read, 01 write, 10 direct-store, 11 external-control |
| sp_iack | input | 1 | Address falls in interrupt-acknowledge space |
| sp_flash | input | 1 | Address falls in flash space |
| sp_pci | input | 1 | Address is forwarded to the PCI side |
| burst | input | 1 | Transfer is a burst |
| burst_len | input | BEAT_W | Beats in a burst minus one |
| wait_req | input | 1 | Hold the acknowledge low this cycle |
| flash_wr_en | input | 1 | Flash writes permitted |
| err_en | input | 1 | Error acknowledge enabled |
| pci_abort | input | 1 | Downstream abort of the current PCI transaction |
| ta | output | 1 | Data beat acknowledge |
| tea | output | 1 | Error acknowledge |
| done | output | 1 | Transaction finished (pulse) |

## Verification
The bench targets the edges of the termination logic, and each edge has a typical failure.
- A wait request on the first cycle and a wait between burst beats would expose a design that counts stalled cycles as beats.
- An abort that arrives during a wait, after two beats, would catch a design that lets the wait mask the error or drops the earlier beats.
- Unsupported transfers with error signalling disabled must still deliver every beat; a wrong design leaves the bus waiting or pulses `tea` anyway.
- A flash write with writes enabled, a read to interrupt-acknowledge space, and an abort on a non-PCI transfer all look close to an error case; a misclassifying design would answer them with `tea`.
- A `ts` raised mid-burst would show up as extra acknowledges if the block restarted.

// File: rtl/xfer_term_pkg.sv
package xfer_term_pkg;

   typedef enum logic [1:0] {
      TT_READ   = 2'b00,
      TT_WRITE  = 2'b01,
      TT_DSTORE = 2'b10,
      TT_EXTCTL = 2'b11
   } ttype_e;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_DATA = 1'b1
   } phase_e;

   typedef struct packed {
      logic unsup;   // statically unsupported at start
      logic pci;     // routed downstream, may be aborted
      logic err_en;  // error acknowledge allowed
   } xfer_ctx_t;

endpackage

// File: rtl/xfer_classify.sv
module xfer_classify
   import xfer_term_pkg::*;
#(
   parameter bit CHECK_FLASH = 1'b1,
   parameter bit CHECK_IACK  = 1'b1
) (
   input  logic [1:0] ttype,
   input  logic       sp_iack,
   input  logic       sp_flash,
   input  logic       sp_pci,
   input  logic       flash_wr_en,
   output logic       unsup,
   output logic       is_pci
);

   logic is_write;
   logic odd_type;
   logic flash_bad;
   logic iack_bad;

   assign is_write = (ttype_e'(ttype) == TT_WRITE);
   assign odd_type = (ttype_e'(ttype) == TT_DSTORE) ||
                     (ttype_e'(ttype) == TT_EXTCTL);

   generate
      if (CHECK_FLASH) begin : g_flash_chk
         assign flash_bad = is_write && sp_flash && !flash_wr_en;
      end else begin : g_flash_off
         assign flash_bad = 1'b0;
      end
      if (CHECK_IACK) begin : g_iack_chk
         assign iack_bad = is_write && sp_iack;
      end else begin : g_iack_off
         assign iack_bad = 1'b0;
      end
   endgenerate

   assign unsup  = odd_type || flash_bad || iack_bad;
   assign is_pci = sp_pci;

endmodule

// File: rtl/xfer_beat_ctr.sv
module xfer_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BEAT_W-1:0] last_in,
   input  logic              step,
   output logic              is_last
);

   logic [BEAT_W-1:0] cnt_q;
   logic [BEAT_W-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= '0;
      end else if (load) begin
         cnt_q  <= '0;
         last_q <= last_in;
      end else if (step && !is_last) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign is_last = (cnt_q == last_q);

   assert_cnt_bound_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= last_q);

   assert_step_advances_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !is_last && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/xfer_term.sv
module xfer_term
   import xfer_term_pkg::*;
#(
   parameter int BEAT_W      = 2,
   parameter bit CHECK_FLASH = 1'b1,
   parameter bit CHECK_IACK  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ts,
   input  logic [1:0]        ttype,
   input  logic              sp_iack,
   input  logic              sp_flash,
   input  logic              sp_pci,
   input  logic              burst,
   input  logic [BEAT_W-1:0] burst_len,
   input  logic              wait_req,
   input  logic              flash_wr_en,
   input  logic              err_en,
   input  logic              pci_abort,
   output logic              ta,
   output logic              tea,
   output logic              done
);

   initial begin
      assert_param_width_R3 : assert (BEAT_W >= 1 && BEAT_W <= 8)
         else $error("BEAT_W out of range");
   end

   phase_e    phase_q;
   xfer_ctx_t ctx_q;
   logic      done_q;
   logic      accept;
   logic      cls_unsup;
   logic      cls_pci;
   logic      in_data;
   logic      err_now;
   logic      last_beat;
   logic      finish;
   logic [BEAT_W-1:0] last_sel;

   xfer_classify #(
      .CHECK_FLASH (CHECK_FLASH),
      .CHECK_IACK  (CHECK_IACK)
   ) u_cls (
      .ttype       (ttype),
      .sp_iack     (sp_iack),
      .sp_flash    (sp_flash),
      .sp_pci      (sp_pci),
      .flash_wr_en (flash_wr_en),
      .unsup       (cls_unsup),
      .is_pci      (cls_pci)
   );

   assign accept   = (phase_q == PH_IDLE) && ts;
   assign last_sel = burst ? burst_len : '0;

   xfer_beat_ctr #(.BEAT_W(BEAT_W)) u_beats (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .last_in (last_sel),
      .step    (ta),
      .is_last (last_beat)
   );

   assign in_data = (phase_q == PH_DATA);
   assign err_now = in_data && ctx_q.err_en &&
                    (ctx_q.unsup || (ctx_q.pci && pci_abort));

   assign tea    = err_now;
   assign ta     = in_data && !err_now && !wait_req;
   assign finish = tea || (ta && last_beat);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         ctx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (accept) begin
            phase_q      <= PH_DATA;
            ctx_q.unsup  <= cls_unsup;
            ctx_q.pci    <= cls_pci;
            ctx_q.err_en <= err_en;
         end else if (finish) begin
            phase_q <= PH_IDLE;
         end
      end
   end

   assign done = done_q;

   assert_ta_tea_excl_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !(ta && tea));

   assert_tea_pulse_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      tea |=> (!tea && !ta));

   assert_done_cause_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(ta || tea));

   assert_done_quiet_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!ta && !tea));

   assert_wait_stalls_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req && !tea) |-> !ta);

   assert_idle_silent_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |-> (!ta && !tea));

endmodule

// File: tb/xfer_term_tb.sv
module xfer_term_tb;

   localparam int BEAT_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ts = 1'b0;
   logic [1:0] ttype = 2'b00;
   logic sp_iack = 1'b0, sp_flash = 1'b0, sp_pci = 1'b0;
   logic burst = 1'b0;
   logic [BEAT_W-1:0] burst_len = '0;
   logic wait_req = 1'b0, flash_wr_en = 1'b0, err_en = 1'b0, pci_abort = 1'b0;
   logic ta, tea, done;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   xfer_term #(.BEAT_W(BEAT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .ts(ts), .ttype(ttype),
      .sp_iack(sp_iack), .sp_flash(sp_flash), .sp_pci(sp_pci),
      .burst(burst), .burst_len(burst_len), .wait_req(wait_req),
      .flash_wr_en(flash_wr_en), .err_en(err_en), .pci_abort(pci_abort),
      .ta(ta), .tea(tea), .done(done)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // Run one transaction. Masks are indexed by data-phase cycle (0 = cycle after accept).
   task automatic run_xfer(input string req, input logic [1:0] tt, input logic iack,
                           input logic fl, input logic pci, input logic bst,
                           input logic [BEAT_W-1:0] blen, input logic fwe, input logic een,
                           input logic [31:0] wmask, input logic [31:0] amask,
                           input logic [31:0] tsmask,
                           input int exp_ta, input int exp_tea, input int exp_done,
                           input int exp_first);
      int n_ta = 0, n_tea = 0, done_at = -1, first_ta = -1, overlap = 0, late_ta = 0;
      @(negedge clk);
      ts = 1'b1; ttype = tt; sp_iack = iack; sp_flash = fl; sp_pci = pci;
      burst = bst; burst_len = blen; flash_wr_en = fwe; err_en = een;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         ts = tsmask[i]; wait_req = wmask[i]; pci_abort = amask[i];
         ttype = 2'b00; sp_iack = 1'b0; sp_flash = 1'b0; sp_pci = 1'b0;
         #1;
         if (done) begin
            done_at = i;
            if (ta || tea) late_ta = 1;
            break;
         end
         if (ta && tea) overlap = 1;
         if (ta) begin
            n_ta++;
            if (first_ta < 0) first_ta = i;
         end
         if (tea) begin
            n_tea++;
            if (ta) overlap = 1;
         end
      end
      ts = 1'b0; wait_req = 1'b0; pci_abort = 1'b0;
      check(req, "ta beats", n_ta, exp_ta);
      check(req, "tea pulses", n_tea, exp_tea);
      check("R11", {req, " done cycle"}, done_at, exp_done);
      check("R9", {req, " ta/tea overlap"}, overlap, 0);
      check("R11", {req, " ack in done cycle"}, late_ta, 0);
      if (exp_first >= 0) check(req, "first ta cycle", first_ta, exp_first);
      // quiet afterwards: nothing restarts
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         if (ta || tea || done) late_ta = 1;
      end
      check("R12", {req, " quiet after end"}, late_ta, 0);
   endtask

   task automatic t_reset();
      #1;
      check("R1", "ta in reset", ta, 0);
      check("R1", "tea in reset", tea, 0);
      check("R1", "done in reset", done, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R1", "idle ta/tea/done", {ta, tea, done}, 0);
   endtask

   task automatic t_single();
      run_xfer("R2", 2'b00, 0, 0, 0, 0, 2'd3, 0, 1, 0, 0, 0, 1, 0, 1, 0);
      run_xfer("R4", 2'b01, 0, 0, 0, 0, 2'd0, 0, 1, 32'b11, 0, 0, 1, 0, 3, 2);
   endtask

   task automatic t_burst();
      run_xfer("R3", 2'b00, 0, 0, 0, 1, 2'd3, 0, 1, 0, 0, 0, 4, 0, 4, 0);
      run_xfer("R3", 2'b01, 0, 0, 1, 1, 2'd1, 0, 1, 0, 0, 0, 2, 0, 2, 0);
      // waits at cycles 1 and 3
      run_xfer("R4", 2'b00, 0, 0, 0, 1, 2'd3, 0, 1, 32'b1010, 0, 0, 4, 0, 6, 0);
   endtask

   task automatic t_classify();
      run_xfer("R5", 2'b10, 0, 0, 0, 0, 2'd0, 1, 1, 0, 0, 0, 0, 1, 1, -1);
      run_xfer("R8", 2'b11, 0, 0, 0, 1, 2'd3, 1, 1, 32'b1, 0, 0, 0, 1, 1, -1);
      run_xfer("R6", 2'b01, 1, 0, 0, 0, 2'd0, 1, 1, 0, 0, 0, 0, 1, 1, -1);
      run_xfer("R6", 2'b01, 0, 1, 0, 0, 2'd0, 0, 1, 0, 0, 0, 0, 1, 1, -1);
      run_xfer("R6", 2'b01, 0, 1, 0, 1, 2'd3, 1, 1, 0, 0, 0, 4, 0, 4, 0);
      run_xfer("R6", 2'b00, 1, 1, 0, 0, 2'd0, 0, 1, 0, 0, 0, 1, 0, 1, 0);
   endtask

   task automatic t_abort();
      // abort at cycle 2 while waiting, after two beats
      run_xfer("R7", 2'b00, 0, 0, 1, 1, 2'd3, 1, 1, 32'b100, 32'b100, 0, 2, 1, 3, 0);
      run_xfer("R7", 2'b00, 0, 0, 0, 1, 2'd3, 1, 1, 0, 32'b10, 0, 4, 0, 4, 0);
   endtask

   task automatic t_err_off();
      run_xfer("R10", 2'b10, 0, 0, 0, 1, 2'd3, 1, 0, 0, 0, 0, 4, 0, 4, 0);
      run_xfer("R10", 2'b01, 1, 0, 0, 0, 2'd0, 1, 0, 0, 0, 0, 1, 0, 1, 0);
      run_xfer("R10", 2'b00, 0, 0, 1, 1, 2'd3, 1, 0, 0, 32'b11, 0, 4, 0, 4, 0);
   endtask

   task automatic t_ts_busy();
      run_xfer("R12", 2'b00, 0, 0, 0, 1, 2'd3, 1, 1, 32'b10, 0, 32'b1111, 4, 0, 5, 0);
   endtask

   initial begin
      t_reset();
      t_single();
      t_burst();
      t_classify();
      t_abort();
      t_err_off();
      t_ts_busy();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule